// File: doc/BRIEF.md
# BCD Calendar Timekeeper

This block keeps wall-clock time and calendar date in packed BCD inside a bank of sixteen byte-wide registers. A sub-second tick input is divided down by a prescaler. On each whole second the seconds, minutes, hours, weekday, day of month, month and two-digit year advance. The date rollover follows the month length and the leap-year rule. Hours can be kept in 24-hour form or in 12-hour form with an afternoon marker.

Two alarm comparators watch the running time. The first compares seconds, minutes, hours and either the weekday or the day of month. The second compares minutes, hours and weekday or day of month, and fires only at the start of a minute. Each raises a sticky flag, and an active-low interrupt pin reports enabled flags when the pin is armed.

A control byte can halt timekeeping. A status byte records lost time, and software clears its flags by writing zero. A host reaches every register through a plain address/data/strobe port, and reads are combinational.

Top module: `bcd_timekeeper`

## Requirements
- R1: After reset the time bytes at 0x00..0x06 read 00,00,00,01,01,01,00, the control byte at 0x0E reads 0x00, the status byte at 0x0F reads 0x80 and irq_n_o is high.
- R2: In 24-hour mode (hours bit 6 clear, BCD 00..23 in bits 5:0), seconds wrap 59→00 and carry into minutes, and minutes wrap 59→00 and carry into hours. Hours wrap 23→00 and carry into the day.
- R3: In 12-hour mode (hours bit 6 set, bit 5 = PM, BCD 01..12 in bits 4:0), 11→12 toggles bit 5 and 12→01 leaves it. Only the step from 11 PM to 12 AM carries into the day.
- R4: On a day carry, the weekday (0x03) steps 1..7 and wraps to 1. The date (0x04) wraps to 01 after 31, after 30 for months 04, 06, 09 and 11, and after 28 for month 02, or after 29 when the year (0x06) is divisible by 4. The month (0x05) wraps 12→01 and carries into the year, which wraps 99→00.
- R5: While control bit 7 is set, the time bytes do not change, and status bit 7 (oscillator failure) is set.
- R6: A write to 0x0F clears each status bit (0, 1, 7) written as 0 and leaves unchanged each bit written as 1.
- R7: These bits read zero whatever is written: bit 7 of 0x00..0x02, bits 7:3 of 0x03, bits 7:6 of 0x04, bits 6:5 of 0x05 and 0x0E, and bits 6:2 of 0x0F.
- R8: A second elapses after SUBTICKS accepted ticks. A write to 0x00 restarts the count, so the next increment comes SUBTICKS ticks after the write.
- R9: Status bit 0 is set on the second at which seconds, minutes and hours (bits 6:0 of 0x07..0x09) equal the new time. In the same second the day byte at 0x0A must also match: when its bit 6 is set, its bits 2:0 are compared to the weekday; when bit 6 is clear, its bits 5:0 are compared to the date.
- R10: Status bit 1 is set on the second at which the new seconds are 00 and minutes, hours and day byte (0x0B..0x0D, same day/date selection) match. The alarm does not fire at any other second.
- R11: irq_n_o is low exactly when control bit 2 is set and some status bit n (n = 0 or 1) is set together with control bit n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Sub-second tick, one clock wide |
| wr_en_i | input | 1 | Write strobe for the addressed byte |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the addressed register (combinational) |
| irq_n_o | output | 1 | Active-low alarm interrupt |

## Verification
The calendar is driven from time points placed one second before each kind of carry: a plain seconds step, a BCD digit step in the hours, the end of a short month, the end of February in leap and non-leap years (year 00 included), and the year wrap. The 12-hour points separate the PM toggle at 11→12, the plain 12→01 step and the day carry that only 11 PM causes. The alarm patterns pair a matching setup with one that differs only in the day/date byte, and the second alarm is also stepped past its minute to show that it ignores the later seconds. The interrupt is then toggled through its enable and arm bits while the flags stay put.

// File: rtl/tk_pkg.sv
package tk_pkg;

  localparam int NTIME    = 7;
  localparam int IDX_SEC  = 0;
  localparam int IDX_MIN  = 1;
  localparam int IDX_HR   = 2;
  localparam int IDX_DOW  = 3;
  localparam int IDX_DATE = 4;
  localparam int IDX_MON  = 5;
  localparam int IDX_YR   = 6;

  localparam int A1_BYTES = 4;
  localparam int A2_BYTES = 3;
  localparam logic [3:0] A1_BASE   = 4'h7;
  localparam logic [3:0] A2_BASE   = 4'hB;
  localparam logic [3:0] ADDR_CTRL = 4'hE;
  localparam logic [3:0] ADDR_STAT = 4'hF;

  localparam int CTRL_A1EN = 0;
  localparam int CTRL_A2EN = 1;
  localparam int CTRL_ARM  = 2;
  localparam int CTRL_HALT = 7;
  localparam int ST_A1  = 0;
  localparam int ST_A2  = 1;
  localparam int ST_OSF = 7;

  typedef logic [NTIME-1:0][7:0] tk_time_t;

  // storage bits kept per address; the rest read zero
  function automatic logic [7:0] keep_mask(input logic [3:0] a);
    case (a)
      4'h0, 4'h1, 4'h2: keep_mask = 8'h7F;
      4'h3:             keep_mask = 8'h07;
      4'h4:             keep_mask = 8'h3F;
      4'h5:             keep_mask = 8'h9F;
      ADDR_CTRL:        keep_mask = 8'h9F;
      ADDR_STAT:        keep_mask = 8'h83;
      default:          keep_mask = 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) bcd_inc = {v[7:4] + 4'd1, 4'd0};
    else                bcd_inc = v + 8'd1;
  endfunction

  function automatic logic is_leap(input logic [7:0] yr);
    logic [7:0] bin;
    bin = 8'(yr[7:4]) * 8'd10 + 8'(yr[3:0]);
    is_leap = (bin[1:0] == 2'b00);
  endfunction

  function automatic logic [7:0] month_end(input logic [4:0] mon, input logic [7:0] yr);
    case (mon)
      5'h02:                      month_end = is_leap(yr) ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: month_end = 8'h30;
      default:                    month_end = 8'h31;
    endcase
  endfunction

  function automatic logic [7:0] hour_next(input logic [7:0] hr, output logic day_cy);
    logic [7:0] h;
    logic       pm;
    day_cy = 1'b0;
    if (hr[6]) begin
      h  = {3'b000, hr[4:0]};
      pm = hr[5];
      if (h >= 8'h12) h = 8'h01;
      else if (h == 8'h11) begin
        h      = 8'h12;
        day_cy = pm;
        pm     = ~pm;
      end else h = bcd_inc(h);
      hour_next = {1'b0, 1'b1, pm, h[4:0]};
    end else begin
      if (hr[5:0] >= 6'h23) begin
        hour_next = 8'h00;
        day_cy    = 1'b1;
      end else hour_next = bcd_inc({2'b00, hr[5:0]});
    end
  endfunction

endpackage

// File: rtl/tk_prescaler.sv
module tk_prescaler #(
  parameter  int SUBTICKS = 4,
  localparam int PW = (SUBTICKS > 1) ? $clog2(SUBTICKS) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic tick_i,
  input  logic clr_i,
  output logic sec_evt_o
);

  logic [PW-1:0] phase_q;
  logic          at_last;

  assign at_last   = (phase_q == PW'(SUBTICKS - 1));
  assign sec_evt_o = run_i && tick_i && at_last && !clr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               phase_q <= '0;
    else if (clr_i)           phase_q <= '0;
    else if (run_i && tick_i) phase_q <= at_last ? '0 : phase_q + PW'(1);
  end

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(phase_q) < SUBTICKS); // R8

  AST_CLEAR_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (phase_q == '0)); // R8

endmodule

// File: rtl/tk_calendar.sv
module tk_calendar
  import tk_pkg::*;
(
  input  tk_time_t cur_i,
  output tk_time_t nxt_o
);

  logic       cy_min, cy_hr, cy_day, cy_mon, cy_yr;
  logic [7:0] hr_n;
  logic       hr_cy;

  always_comb begin
    nxt_o  = cur_i;
    cy_min = 1'b0;
    cy_hr  = 1'b0;
    cy_mon = 1'b0;
    cy_yr  = 1'b0;
    hr_n   = hour_next(cur_i[IDX_HR], hr_cy);
    cy_day = 1'b0;

    if (cur_i[IDX_SEC] >= 8'h59) begin
      nxt_o[IDX_SEC] = 8'h00;
      cy_min         = 1'b1;
    end else nxt_o[IDX_SEC] = bcd_inc(cur_i[IDX_SEC]);

    if (cy_min) begin
      if (cur_i[IDX_MIN] >= 8'h59) begin
        nxt_o[IDX_MIN] = 8'h00;
        cy_hr          = 1'b1;
      end else nxt_o[IDX_MIN] = bcd_inc(cur_i[IDX_MIN]);
    end

    if (cy_hr) begin
      nxt_o[IDX_HR] = hr_n;
      cy_day        = hr_cy;
    end

    if (cy_day) begin
      if (cur_i[IDX_DOW] >= 8'h07 || cur_i[IDX_DOW] == 8'h00) nxt_o[IDX_DOW] = 8'h01;
      else nxt_o[IDX_DOW] = cur_i[IDX_DOW] + 8'h01;
      if (cur_i[IDX_DATE] >= month_end(cur_i[IDX_MON][4:0], cur_i[IDX_YR])) begin
        nxt_o[IDX_DATE] = 8'h01;
        cy_mon          = 1'b1;
      end else nxt_o[IDX_DATE] = bcd_inc(cur_i[IDX_DATE]);
    end

    if (cy_mon) begin
      if (cur_i[IDX_MON][4:0] >= 5'h12) begin
        nxt_o[IDX_MON] = {cur_i[IDX_MON][7], 7'h01};
        cy_yr          = 1'b1;
      end else nxt_o[IDX_MON] = {cur_i[IDX_MON][7], 2'b00,
                                 bcd_inc({3'b000, cur_i[IDX_MON][4:0]})[4:0]};
    end

    if (cy_yr) begin
      if (cur_i[IDX_YR] >= 8'h99) nxt_o[IDX_YR] = 8'h00;
      else nxt_o[IDX_YR] = bcd_inc(cur_i[IDX_YR]);
    end
  end

endmodule

// File: rtl/tk_alarm_match.sv
module tk_alarm_match
  import tk_pkg::*;
#(
  parameter  bit HAS_SEC = 1'b1,
  localparam int NB  = HAS_SEC ? 4 : 3,
  localparam int OFS = HAS_SEC ? 1 : 0
) (
  input  tk_time_t          now_i,
  input  logic [NB-1:0][7:0] alm_i,
  output logic              hit_o
);

  logic sec_ok, min_ok, hr_ok, day_ok;
  logic [7:0] day_b;

  generate
    if (HAS_SEC) begin : g_sec_cmp
      assign sec_ok = (alm_i[0][6:0] == now_i[IDX_SEC][6:0]);
    end else begin : g_minute_edge
      assign sec_ok = (now_i[IDX_SEC] == 8'h00);
    end
  endgenerate

  assign day_b  = alm_i[OFS+2];
  assign min_ok = (alm_i[OFS][6:0]   == now_i[IDX_MIN][6:0]);
  assign hr_ok  = (alm_i[OFS+1][6:0] == now_i[IDX_HR][6:0]);
  assign day_ok = day_b[6] ? (day_b[2:0] == now_i[IDX_DOW][2:0])
                           : (day_b[5:0] == now_i[IDX_DATE][5:0]);
  assign hit_o  = sec_ok && min_ok && hr_ok && day_ok;

endmodule

// File: rtl/bcd_timekeeper.sv
module bcd_timekeeper
  import tk_pkg::*;
#(
  parameter int SUBTICKS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       wr_en_i,
  input  logic [3:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       irq_n_o
);

  tk_time_t                 time_q, time_adv, time_nxt;
  logic [A1_BYTES-1:0][7:0] a1_q;
  logic [A2_BYTES-1:0][7:0] a2_q;
  logic [7:0]               ctrl_q, stat_q, stat_nxt, wdata_m;
  logic                     sec_evt, sec_wr, a1_hit, a2_hit, halted;

  assign halted  = ctrl_q[CTRL_HALT];
  assign sec_wr  = wr_en_i && (addr_i == 4'h0);
  assign wdata_m = wdata_i & keep_mask(addr_i);

  tk_prescaler #(.SUBTICKS(SUBTICKS)) u_presc (
    .clk(clk), .rst_n(rst_n), .run_i(!halted), .tick_i(tick_i),
    .clr_i(sec_wr), .sec_evt_o(sec_evt)
  );

  tk_calendar u_cal (.cur_i(time_q), .nxt_o(time_adv));

  tk_alarm_match #(.HAS_SEC(1'b1)) u_alm1 (.now_i(time_adv), .alm_i(a1_q), .hit_o(a1_hit));
  tk_alarm_match #(.HAS_SEC(1'b0)) u_alm2 (.now_i(time_adv), .alm_i(a2_q), .hit_o(a2_hit));

  always_comb begin
    time_nxt = sec_evt ? time_adv : time_q;
    if (wr_en_i && addr_i < 4'(NTIME)) time_nxt[addr_i[2:0]] = wdata_m;
  end

  always_comb begin
    stat_nxt = stat_q;
    if (wr_en_i && addr_i == ADDR_STAT) stat_nxt = stat_q & wdata_i & keep_mask(ADDR_STAT);
    if (sec_evt && a1_hit) stat_nxt[ST_A1]  = 1'b1;
    if (sec_evt && a2_hit) stat_nxt[ST_A2]  = 1'b1;
    if (halted)            stat_nxt[ST_OSF] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q           <= '0;
      time_q[IDX_DOW]  <= 8'h01;
      time_q[IDX_DATE] <= 8'h01;
      time_q[IDX_MON]  <= 8'h01;
      a1_q             <= '0;
      a2_q             <= '0;
      ctrl_q           <= 8'h00;
      stat_q           <= 8'h80;
    end else begin
      time_q <= time_nxt;
      stat_q <= stat_nxt;
      if (wr_en_i) begin
        if (addr_i >= A1_BASE && addr_i < A2_BASE) a1_q[2'(addr_i - A1_BASE)] <= wdata_m;
        if (addr_i >= A2_BASE && addr_i < ADDR_CTRL) a2_q[2'(addr_i - A2_BASE)] <= wdata_m;
        if (addr_i == ADDR_CTRL) ctrl_q <= wdata_m;
      end
    end
  end

  always_comb begin
    if (addr_i < 4'(NTIME))                          rdata_o = time_q[addr_i[2:0]];
    else if (addr_i < A2_BASE)                       rdata_o = a1_q[2'(addr_i - A1_BASE)];
    else if (addr_i < ADDR_CTRL)                     rdata_o = a2_q[2'(addr_i - A2_BASE)];
    else if (addr_i == ADDR_CTRL)                    rdata_o = ctrl_q;
    else                                             rdata_o = stat_q;
  end

  assign irq_n_o = !(ctrl_q[CTRL_ARM] &&
                     ((stat_q[ST_A1] && ctrl_q[CTRL_A1EN]) || (stat_q[ST_A2] && ctrl_q[CTRL_A2EN])));

  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_evt && time_q[IDX_SEC] == 8'h59 && !wr_en_i) |=> (time_q[IDX_SEC] == 8'h00)); // R2

  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !wr_en_i) |=> $stable(time_q)); // R5

  AST_HALT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> stat_q[ST_OSF]); // R5

  AST_DOW_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i == 4'h3) |-> (rdata_o[7:3] == 5'b0)); // R7

  AST_A2_MINUTE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(stat_q[ST_A2]) && !$past(wr_en_i)) |-> (time_q[IDX_SEC] == 8'h00)); // R10

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n_o |-> (stat_q[1:0] != 2'b00)); // R11

endmodule

// File: tb/bcd_timekeeper_bench.sv
module bcd_timekeeper_bench;

  localparam int CLK_PERIOD = 10;
  localparam int SUB = 4;
  localparam int NVEC = 13;

  // {sec,min,hr,dow,date,mon,yr} before, then expected after one second
  localparam logic [111:0] VEC [NVEC] = '{
    112'h56341203150623_57341203150623, // R2 plain step
    112'h59592307311299_00000001010100, // R4 year wrap
    112'h59592302280224_00000003290224, // R4 leap Feb
    112'h59592302280223_00000003010323, // R4 common Feb
    112'h59592304290224_00000005010324, // R4 leap Feb end
    112'h59592305300421_00000006010521, // R4 30-day month
    112'h59592301300121_00000002310121, // R4 31-day month
    112'h59597105100322_00005206110322, // R3 11PM -> 12AM
    112'h59595105100322_00007205100322, // R3 11AM -> 12PM
    112'h59597205100322_00006105100322, // R3 12 -> 01
    112'h59590905100322_00001005100322, // R2 digit carry
    112'h59592306300900_00000007011000, // R4 month BCD step
    112'h59592306280200_00000007290200  // R4 year 00 leap
  };

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic irq_n;
  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_timekeeper #(.SUBTICKS(SUB)) u_bcd_timekeeper (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_n_o(irq_n)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic set_time(input logic [55:0] t);
    for (int i = 0; i < 7; i++) wr(4'(i), t[55-8*i -: 8]);
  endtask

  task automatic get_time(output logic [55:0] t);
    logic [7:0] d;
    t = '0;
    for (int i = 0; i < 7; i++) begin
      rd(4'(i), d);
      t = {t[47:0], d};
    end
  endtask

  task automatic get_irq(output logic v);
    @(negedge clk); #1 v = irq_n;
  endtask

  initial begin
    logic [55:0] t;
    logic [7:0]  d;
    logic        irq;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    get_time(t);  chk("R1 time", t, 56'h00000001010100);
    rd(4'hE, d);  chk("R1 ctrl", d, 8'h00);
    rd(4'hF, d);  chk("R1 status", d, 8'h80);
    get_irq(irq); chk("R1 irq", irq, 1'b1);

    // R2 R3 R4 vector walk
    for (int k = 0; k < NVEC; k++) begin
      set_time(VEC[k][111:56]);
      ticks(SUB);
      get_time(t);
      chk($sformatf("R2/R3/R4 vector %0d", k), t, VEC[k][55:0]);
    end

    // R6 write-zero clears, writing one leaves bits
    wr(4'hF, 8'h00); rd(4'hF, d); chk("R6 clear", d, 8'h00);
    wr(4'hF, 8'hFF); rd(4'hF, d); chk("R6 write one no effect", d, 8'h00);

    // R7 reserved bits
    wr(4'h3, 8'hFF); rd(4'h3, d); chk("R7 weekday", d, 8'h07);
    wr(4'h5, 8'hFF); rd(4'h5, d); chk("R7 month", d, 8'h9F);
    wr(4'h0, 8'hFF); rd(4'h0, d); chk("R7 seconds", d, 8'h7F);
    wr(4'h4, 8'hFF); rd(4'h4, d); chk("R7 date", d, 8'h3F);
    wr(4'hE, 8'h7F); rd(4'hE, d); chk("R7 ctrl", d, 8'h1F);
    wr(4'hE, 8'h00);

    // R5 halt
    set_time(56'h30201203150623);
    wr(4'hF, 8'h00);
    wr(4'hE, 8'h80);
    ticks(SUB * 3);
    get_time(t);  chk("R5 time held", t, 56'h30201203150623);
    rd(4'hF, d);  chk("R5 failure flag", d, 8'h80);
    wr(4'hE, 8'h00);
    wr(4'hF, 8'h00);
    rd(4'hF, d);  chk("R6 flag cleared after restart", d, 8'h00);

    // R8 phase restart on seconds write
    wr(4'h0, 8'h10);
    ticks(SUB - 1);
    wr(4'h0, 8'h20);
    ticks(SUB - 1);
    rd(4'h0, d);  chk("R8 no early step", d, 8'h20);
    ticks(1);
    rd(4'h0, d);  chk("R8 step after full count", d, 8'h21);

    // R9 alarm 1 with weekday select
    set_time(56'h05001003150623);
    wr(4'h7, 8'h06); wr(4'h8, 8'h00); wr(4'h9, 8'h10); wr(4'hA, 8'h43);
    wr(4'hF, 8'h00); wr(4'hE, 8'h05);
    wr(4'h0, 8'h05);
    ticks(SUB);
    rd(4'hF, d);  chk("R9 alarm1 flag", d, 8'h01);
    get_irq(irq); chk("R11 irq asserted", irq, 1'b0);
    wr(4'hF, 8'h00);
    get_irq(irq); chk("R11 irq released", irq, 1'b1);
    wr(4'hA, 8'h14);
    wr(4'h0, 8'h05);
    ticks(SUB);
    rd(4'hF, d);  chk("R9 date mismatch", d, 8'h00);

    // R10 alarm 2, R11 enable/arm gating
    wr(4'hE, 8'h04);
    wr(4'hB, 8'h05); wr(4'hC, 8'h10); wr(4'hD, 8'h15);
    set_time(56'h59041003150623);
    ticks(SUB);
    rd(4'hF, d);  chk("R10 alarm2 flag", d, 8'h02);
    get_irq(irq); chk("R11 disabled source", irq, 1'b1);
    wr(4'hE, 8'h06);
    get_irq(irq); chk("R11 enabled source", irq, 1'b0);
    wr(4'hE, 8'h02);
    get_irq(irq); chk("R11 pin unarmed", irq, 1'b1);
    wr(4'hF, 8'h00);
    ticks(SUB);
    rd(4'hF, d);  chk("R10 later second ignored", d, 8'h00);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule